// File: doc/BRIEF.md
# Line-change timestamp capture engine

The block watches a bank of digital input lines, such as general-purpose pins or on-chip interrupt request lines, and records a timestamp whenever an enabled line changes level in either direction. The timestamp is the value of an external free-running counter. Each record also holds the number of the line and the level it moved to. Records go into an internal event FIFO. Software reads them through a small register window and removes each one with a pop write.

The lines are arranged as 32-bit slices, one enable bit per line. The slice count is a build parameter; the supported values are 3 (96 lines) and 11 (352 lines). Every line passes through a two-flop synchroniser. A change is found by comparing the synchronised value with the last level the block accepted.

When several enabled lines change in the same cycle, each change is held as a pending bit. The pending bits drain into the FIFO one per cycle, lowest line first, and every record in the batch carries the counter value from the detection cycle. A single level interrupt is raised while the FIFO holds at least a programmable number of entries. A full FIFO drops new records and sets a sticky overflow flag.

Top module: `line_stamp_engine`

## Requirements
- R1: After reset the interrupt is low, the FIFO is empty, every enable bit is 0, the overflow flag is 0 and the threshold reads back as 1.
- R2: On an enabled line, a rising change and a falling change each produce exactly one record. The info word at address 19 holds the line index in bits 15:0 and the new level in bit 16. Bit 31 of that word is 1 while the FIFO is not empty.
- R3: The stamp, read at address 18, is the counter value sampled on the third rising clock edge after the input changes. The record for the lowest changed line is counted in the FIFO from the fourth edge.
- R4: A line whose enable bit is 0 never produces a record.
- R5: When several enabled lines change together, their records enter the FIFO one per cycle in ascending line order, and all of them carry the same stamp.
- R6: The interrupt is high exactly while the FIFO occupancy is at or above the effective threshold, and it falls as soon as a pop takes the occupancy below it.
- R7: The threshold register is at address 16. A write of 0 gives an effective threshold of 1, and a value above the FIFO depth gives the depth. A read returns the effective value.
- R8: When the FIFO is full, further records are dropped and the overflow flag (status address 17, bit 0) is set. The flag is cleared only by writing 1 to that bit; a write of 0 leaves it set. Status bits 31:16 report the occupancy, and bit 1 mirrors the interrupt.
- R9: A write to address 20 pops the oldest record. A pop while the FIFO is empty has no effect. Records leave the FIFO in the order they entered.
- R10: The enable bit for line n is bit n mod 32 of the slice register at address n/32. Each slice register reads back the value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lines_in | input | SLICES*32 | Monitored lines, asynchronous |
| counter_in | input | CNT_W | Free-running system counter |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Occupancy-threshold interrupt |

## Verification
A line change takes three clock edges to reach the capture stage: two synchroniser flops and the capture register. The first record then enters the FIFO on the fourth edge, and each further line in the same batch follows one edge later. The interrupt follows occupancy in the same cycle. The bench therefore checks the interrupt on the negative edge between the third and fourth edges and again after the fourth. Before reading records back, it waits long enough for the largest batch to drain. The expected stamp is derived from the counter value the bench held when it drove the change, plus two.

// File: rtl/lse_pkg.sv
package lse_pkg;
    localparam int SLICE_W = 32;
    localparam int ADDR_W  = 5;

    localparam logic [ADDR_W-1:0] A_THRESH = 5'd16;
    localparam logic [ADDR_W-1:0] A_STATUS = 5'd17;
    localparam logic [ADDR_W-1:0] A_STAMP  = 5'd18;
    localparam logic [ADDR_W-1:0] A_INFO   = 5'd19;
    localparam logic [ADDR_W-1:0] A_POP    = 5'd20;

    // Info word layout
    localparam int INFO_LVL_BIT   = 16;
    localparam int INFO_VALID_BIT = 31;
    // Status word layout
    localparam int STAT_OVF_BIT = 0;
    localparam int STAT_IRQ_BIT = 1;
    localparam int STAT_OCC_LSB = 16;

    // Effective threshold: zero maps to one, large values saturate at depth
    function automatic logic [8:0] clamp_thresh(input logic [31:0] w, input int unsigned depth);
        if (w == 32'd0)
            return 9'd1;
        else if (w > 32'(depth))
            return 9'(depth);
        else
            return w[8:0];
    endfunction
endpackage

// File: rtl/lse_line_sense.sv
module lse_line_sense #(
    parameter int LINES = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines_in,
    input  logic             take,
    output logic [LINES-1:0] changed,
    output logic [LINES-1:0] level
);
    typedef struct packed {
        logic [LINES-1:0] s1;
        logic [LINES-1:0] s2;
        logic [LINES-1:0] seen;
    } sense_t;

    sense_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = lines_in;
        st_d.s2 = st_q.s1;
        // accepted level only advances when a new batch may be taken
        if (take)
            st_d.seen = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign changed = st_q.s2 ^ st_q.seen;
    assign level   = st_q.seen;
endmodule

// File: rtl/lse_pend_arb.sv
module lse_pend_arb #(
    parameter int LINES = 96,
    parameter int CNT_W = 32,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] hits,
    input  logic [CNT_W-1:0] counter_in,
    input  logic [LINES-1:0] level,
    output logic             idle,
    output logic             ev_valid,
    output logic [IDX_W-1:0] ev_idx,
    output logic [CNT_W-1:0] ev_stamp,
    output logic             ev_level
);
    typedef struct packed {
        logic [LINES-1:0] pend;
        logic [CNT_W-1:0] stamp;
    } arb_t;

    arb_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.pend == '0) begin
            st_d.pend  = hits;
            st_d.stamp = counter_in;
        end else begin
            // retire the lowest pending line
            st_d.pend = st_q.pend & (st_q.pend - 1'b1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        ev_idx = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (st_q.pend[i])
                ev_idx = IDX_W'(i);
        end
    end

    assign idle     = (st_q.pend == '0);
    assign ev_valid = !idle;
    assign ev_stamp = st_q.stamp;
    assign ev_level = level[ev_idx];
endmodule

// File: rtl/lse_event_fifo.sv
module lse_event_fifo #(
    parameter int DW    = 40,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [DW-1:0]    wdata,
    input  logic             pop,
    output logic [DW-1:0]    rdata,
    output logic [OCC_W-1:0] occ,
    output logic             full
);
    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [OCC_W-1:0] cnt;
    } fifo_t;

    fifo_t st_d, st_q;
    logic [DW-1:0] mem [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        do_push = push && (st_q.cnt != OCC_W'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        st_d    = st_q;
        if (do_push)
            st_d.wp = st_q.wp + 1'b1;
        if (do_pop)
            st_d.rp = st_q.rp + 1'b1;
        if (do_push && !do_pop)
            st_d.cnt = st_q.cnt + 1'b1;
        else if (do_pop && !do_push)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push)
            mem[st_q.wp] <= wdata;
    end

    assign rdata = mem[st_q.rp];
    assign occ   = st_q.cnt;
    assign full  = (st_q.cnt == OCC_W'(DEPTH));
endmodule

// File: rtl/line_stamp_engine.sv
module line_stamp_engine #(
    parameter int SLICES     = 3,
    parameter int CNT_W      = 32,
    parameter int FIFO_DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SLICES*32-1:0]   lines_in,
    input  logic [CNT_W-1:0]       counter_in,
    input  logic                   reg_we,
    input  logic [4:0]             reg_addr,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    output logic                   irq
);
    import lse_pkg::*;

    localparam int LINES = SLICES * SLICE_W;
    localparam int IDX_W = $clog2(LINES);
    localparam int DW    = CNT_W + IDX_W + 1;
    localparam int OCC_W = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic [LINES-1:0] en;
        logic [8:0]       thr;
        logic             ovf;
    } regs_t;

    regs_t rg_d, rg_q;

    logic [LINES-1:0] changed, level;
    logic             idle, ev_valid, ev_level, fifo_full, pop;
    logic [IDX_W-1:0] ev_idx;
    logic [CNT_W-1:0] ev_stamp;
    logic [DW-1:0]    head;
    logic [OCC_W-1:0] occ;

    lse_line_sense #(.LINES(LINES)) u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_in (lines_in),
        .take     (idle),
        .changed  (changed),
        .level    (level)
    );

    lse_pend_arb #(.LINES(LINES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .hits       (changed & rg_q.en),
        .counter_in (counter_in),
        .level      (level),
        .idle       (idle),
        .ev_valid   (ev_valid),
        .ev_idx     (ev_idx),
        .ev_stamp   (ev_stamp),
        .ev_level   (ev_level)
    );

    lse_event_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (ev_valid),
        .wdata ({ev_level, ev_idx, ev_stamp}),
        .pop   (pop),
        .rdata (head),
        .occ   (occ),
        .full  (fifo_full)
    );

    always_comb begin
        rg_d = rg_q;
        pop  = reg_we && (reg_addr == A_POP);
        if (reg_we) begin
            for (int k = 0; k < SLICES; k++) begin
                if (reg_addr == 5'(k))
                    rg_d.en[k*SLICE_W +: SLICE_W] = reg_wdata;
            end
            if (reg_addr == A_THRESH)
                rg_d.thr = clamp_thresh(reg_wdata, FIFO_DEPTH);
            if (reg_addr == A_STATUS && reg_wdata[STAT_OVF_BIT])
                rg_d.ovf = 1'b0;
        end
        // a drop in the same cycle as a clear wins
        if (ev_valid && fifo_full)
            rg_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q     <= '0;
            rg_q.thr <= 9'd1;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign irq = (32'(occ) >= 32'(rg_q.thr));

    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < SLICES; k++) begin
            if (reg_addr == 5'(k))
                reg_rdata = rg_q.en[k*SLICE_W +: SLICE_W];
        end
        case (reg_addr)
            A_THRESH: reg_rdata = 32'(rg_q.thr);
            A_STATUS: begin
                reg_rdata[STAT_OVF_BIT]            = rg_q.ovf;
                reg_rdata[STAT_IRQ_BIT]            = irq;
                reg_rdata[STAT_OCC_LSB +: OCC_W]   = occ;
            end
            A_STAMP: reg_rdata = 32'(head[CNT_W-1:0]);
            A_INFO: begin
                reg_rdata[IDX_W-1:0]      = head[CNT_W +: IDX_W];
                reg_rdata[INFO_LVL_BIT]   = head[DW-1];
                reg_rdata[INFO_VALID_BIT] = (occ != '0);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lse_checker.sv
module lse_checker #(
    parameter int DEPTH = 16,
    parameter int OCC_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic [OCC_W-1:0] occ,
    input logic [8:0]       thr,
    input logic             ovf,
    input logic             reg_we,
    input logic [4:0]       reg_addr,
    input logic [31:0]      reg_wdata
);
    AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        32'(occ) <= 32'(DEPTH)); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(reg_we && reg_addr == 5'd17 && reg_wdata[0])) |=> ovf); // R8
    AST_THR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (thr >= 9'd1) && (32'(thr) <= 32'(DEPTH))); // R7
    AST_IRQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> !irq); // R6
    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (32'(occ) >= 32'(thr))); // R6
    AST_ONE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (32'(occ) <= 32'($past(occ)) + 32'd1)); // R5
endmodule

bind line_stamp_engine lse_checker #(.DEPTH(FIFO_DEPTH), .OCC_W(OCC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .occ       (occ),
    .thr       (rg_q.thr),
    .ovf       (rg_q.ovf),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata)
);

// File: tb/line_stamp_engine_test.sv
`timescale 1ns/1ps
module line_stamp_engine_test;
    localparam int SLICES = 3;
    localparam int LINES  = SLICES * 32;
    localparam int DEPTH  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [LINES-1:0]  lines = '0;
    logic [31:0]       cnt = 32'h1000_0000;
    logic              reg_we = 1'b0;
    logic [4:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              irq;

    typedef struct {
        logic [31:0] stamp;
        int          idx;
        logic        lvl;
    } exp_t;

    exp_t             sb[$];
    logic [LINES-1:0] en_model = '0;
    int               n_chk = 0;
    int               n_bad = 0;

    always #4 clk = ~clk;
    always_ff @(posedge clk) cnt <= cnt + 1;

    line_stamp_engine #(.SLICES(SLICES), .CNT_W(32), .FIFO_DEPTH(DEPTH)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .lines_in   (lines),
        .counter_in (cnt),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq        (irq)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_slice(input int k, input logic [31:0] v);
        wr(5'(k), v);
        en_model[k*32 +: 32] = v;
    endtask

    // driver: change lines and predict the records they produce
    task automatic toggle(input logic [LINES-1:0] mask);
        logic [31:0] c;
        @(negedge clk);
        c = cnt;
        lines = lines ^ mask;
        for (int i = 0; i < LINES; i++) begin
            if (mask[i] && en_model[i] && sb.size() < DEPTH)
                sb.push_back('{c + 32'd2, i, lines[i]});
        end
    endtask

    task automatic settle();
        repeat (48) @(negedge clk);
    endtask

    // monitor: pop one record and compare it with the scoreboard
    task automatic pop_check(input string tag);
        exp_t        e;
        logic [31:0] info, st;
        e = sb.pop_front();
        rd(5'd19, info);
        check(info[31] == 1'b1, {tag, " valid"}, info[31], 1);
        check(info[15:0] == 16'(e.idx), {tag, " index"}, info[15:0], e.idx);
        check(info[16] == e.lvl, {tag, " level"}, info[16], e.lvl);
        rd(5'd18, st);
        check(st == e.stamp, {tag, " stamp"}, st, e.stamp);
        wr(5'd20, 32'd0);
    endtask

    task automatic drain(input string tag);
        while (sb.size() > 0) pop_check(tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic [LINES-1:0] m;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1 check(irq == 1'b0, "R1 irq", irq, 0);
        rd(5'd17, d); check(d == 32'd0, "R1 status", d, 0);
        rd(5'd16, d); check(d == 32'd1, "R1 threshold", d, 1);
        rd(5'd0, d);  check(d == 32'd0, "R1 enable", d, 0);

        // R10 slice mapping and readback
        set_slice(2, 32'hA5A5_0040);
        rd(5'd2, d); check(d == 32'hA5A5_0040, "R10 slice2", d, 32'hA5A5_0040);
        set_slice(0, 32'h0000_0020);
        set_slice(1, 32'h0000_0100);
        set_slice(2, 32'h0000_0040);
        rd(5'd1, d); check(d == 32'h100, "R10 slice1", d, 32'h100);

        // R2/R3 rising change on line 5 with exact timing
        m = '0; m[5] = 1'b1;
        toggle(m);
        repeat (3) @(negedge clk);
        #1 check(irq == 1'b0, "R3 not yet pushed", irq, 0);
        @(negedge clk);
        #1 check(irq == 1'b1, "R3 pushed on fourth edge", irq, 1);
        drain("R2 rise");
        #1 check(irq == 1'b0, "R6 irq after pop", irq, 0);

        // R2 falling change
        toggle(m); settle(); drain("R2 fall");

        // R4 disabled line 6
        m = '0; m[6] = 1'b1;
        toggle(m); settle();
        rd(5'd17, d); check(d[31:16] == 16'd0, "R4 disabled line", d[31:16], 0);

        // R5 simultaneous lines, ascending, one stamp
        m = '0; m[70] = 1'b1; m[40] = 1'b1; m[6] = 1'b1; m[5] = 1'b1;
        toggle(m); settle();
        rd(5'd17, d); check(d[31:16] == 16'd3, "R5 batch size", d[31:16], 3);
        drain("R5 batch");

        // R7 threshold clamping
        wr(5'd16, 32'd0);   rd(5'd16, d); check(d == 32'd1, "R7 zero", d, 1);
        wr(5'd16, 32'd300); rd(5'd16, d); check(d == 32'd16, "R7 above depth", d, 16);
        wr(5'd16, 32'd3);   rd(5'd16, d); check(d == 32'd3, "R7 in range", d, 3);

        // R6 threshold interrupt
        m = '0; m[5] = 1'b1; m[40] = 1'b1;
        toggle(m); settle();
        #1 check(irq == 1'b0, "R6 two below three", irq, 0);
        m = '0; m[70] = 1'b1;
        toggle(m); settle();
        #1 check(irq == 1'b1, "R6 three reaches three", irq, 1);
        pop_check("R6 pop");
        #1 check(irq == 1'b0, "R6 falls below", irq, 0);
        drain("R9 order");
        wr(5'd16, 32'd1);

        // R8 overflow
        set_slice(0, 32'hFFFF_FFFF);
        m = '0; m[31:0] = 32'hFFFF_FFFF;
        toggle(m); settle();
        rd(5'd17, d);
        check(d[0] == 1'b1, "R8 overflow set", d[0], 1);
        check(d[31:16] == 16'd16, "R8 full occupancy", d[31:16], 16);
        wr(5'd17, 32'd0); rd(5'd17, d); check(d[0] == 1'b1, "R8 zero write keeps", d[0], 1);
        wr(5'd17, 32'd1); rd(5'd17, d); check(d[0] == 1'b0, "R8 one write clears", d[0], 0);
        drain("R8 kept lowest");

        // R9 pop on empty
        wr(5'd20, 32'd0);
        rd(5'd17, d); check(d[31:16] == 16'd0, "R9 empty pop occupancy", d[31:16], 0);
        rd(5'd19, d); check(d[31] == 1'b0, "R9 empty info", d[31], 0);
        m = '0; m[40] = 1'b1;
        toggle(m); settle(); drain("R9 after empty pop");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule